// File: doc/BRIEF.md
# Fixed-Pattern Serial Test Bit Source for T1 and DDS Circuits

This block emits a serial stream for one of thirteen fixed, repeating test patterns used on T1 lines and on digital data service channels. A 4-bit pattern code picks the pattern. Every pattern is made of whole octets, and each octet is sent most significant bit first. One bit is produced for each clock on which the bit enable is high. At the first bit of each pattern period, a one-cycle marker pulse is raised beside that bit.

The block keeps the code of the pattern it last emitted. If the code seen on an enabled clock is different from that stored code, the pattern starts again at bit 0 of the new pattern. This lets a test set step through patterns without stopping the bit clock. If the code is changed and then changed back between two enabled clocks, nothing happens. Framing bits, pseudo-random sequences and line coding are handled elsewhere.

Top module: `ds1_pattern_gen`

## Requirements
- R1: While reset is high, and on the cycle after it is released, bit_o and sop_o are 0. The first enabled bit after reset is bit 0 of the selected pattern, and sop_o is 1 with it.
- R2: On a clock where bit_en_i is low, bit_o keeps its value and sop_o falls to 0. Changing pat_sel_i while bit_en_i is low has no effect on the outputs.
- R3: sop_o is 1 for exactly the one cycle that follows the enabled clock emitting bit 0 of a period. Period lengths in bits are: 8 for codes 0, 1, 2, 3 and 6; 24 for code 4; 16 for code 5; 960 for code 7; 1600 for codes 8 and 9; 128 for codes 10 and 11; 64 for code 12.
- R4: If the code seen on an enabled clock differs from the code of the previously emitted bit, that clock emits bit 0 of the new pattern with sop_o set. A code changed and restored between enabled clocks continues the old pattern without a restart.
- R5: Octets are sent MSB first. Code 2 repeats 80h (one in eight). Code 3 repeats 42h (ones in bit positions 2 and 7). Code 6 repeats 08h (only position 5). Code 5 sends 80h then 00h (a one followed by fifteen zeros).
- R6: Code 4 sends 44h, 00h, 04h. That is three ones in 24 bits, with a run of fifteen zeros.
- R7: Code 0 sends all ones. Code 1 sends all zeros. The unused codes 13 to 15 also send all zeros, with an 8-bit period.
- R8: Code 7 sends 120 octets in this order: 72 of FFh, 4 of AAh, 20 of 10h, 4 of AAh, then 20 of 10h.
- R9: Code 8 sends 100 octets of FFh, then 100 of 00h. Code 9 sends 100 octets of 7Eh, then 100 of 00h.
- R10: Code 10 sends 16 octets of 4Ch. Code 11 sends 16 octets of 40h. Code 12 sends seven FEh octets, then one FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_en_i | input | 1 | Emit one pattern bit on this clock |
| pat_sel_i | input | 4 | Pattern code, 0 to 12 (13 to 15 send zeros) |
| bit_o | output | 1 | Registered serial pattern bit |
| sop_o | output | 1 | One-cycle pulse that marks bit 0 of a period |

## Verification
Both outputs pass through one register. The bit and marker for an enabled clock therefore show up on the ports just after that clock edge. The bench samples them at the following falling edge and pops the expected pair from its queue at that moment. On clocks without enable, the same falling edge checks that the bit held its value and the marker is low. The expected restart points come from a bench model that tracks the code of the last emitted bit, not the current code. This tests both a real mid-period switch and a code that is changed and restored while the enable is low.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int OCT_W = 8;
  localparam int IDX_W = 8;
  localparam int SEL_W = 4;
  localparam int BIT_W = $clog2(OCT_W);

  typedef enum logic [SEL_W-1:0] {
    PAT_ONES   = 4'd0,
    PAT_ZEROS  = 4'd1,
    PAT_1IN8   = 4'd2,
    PAT_2IN8   = 4'd3,
    PAT_3IN24  = 4'd4,
    PAT_1IN16  = 4'd5,
    PAT_PULSE  = 4'd6,
    PAT_T14    = 4'd7,
    PAT_DDS1   = 4'd8,
    PAT_DDS2   = 4'd9,
    PAT_DDS3   = 4'd10,
    PAT_DDS4   = 4'd11,
    PAT_DDS6   = 4'd12
  } pat_e;

  // Octet-run boundaries of the long patterns (exclusive upper ends)
  localparam logic [IDX_W-1:0] T14_HIGH_END  = IDX_W'(72);
  localparam logic [IDX_W-1:0] T14_ALT1_END  = IDX_W'(76);
  localparam logic [IDX_W-1:0] T14_SPRS1_END = IDX_W'(96);
  localparam logic [IDX_W-1:0] T14_ALT2_END  = IDX_W'(100);
  localparam logic [IDX_W-1:0] DDS_HALF      = IDX_W'(100);
  localparam logic [IDX_W-1:0] DDS6_LAST     = IDX_W'(7);

  // Octets in one period of each pattern
  function automatic logic [IDX_W-1:0] period_octets(logic [SEL_W-1:0] s);
    case (pat_e'(s))
      PAT_3IN24:            return IDX_W'(3);
      PAT_1IN16:            return IDX_W'(2);
      PAT_T14:              return IDX_W'(120);
      PAT_DDS1, PAT_DDS2:   return IDX_W'(200);
      PAT_DDS3, PAT_DDS4:   return IDX_W'(16);
      PAT_DDS6:             return IDX_W'(8);
      default:              return IDX_W'(1);
    endcase
  endfunction

  // Octet value at index k of the selected pattern
  function automatic logic [OCT_W-1:0] octet_of(logic [SEL_W-1:0] s,
                                                logic [IDX_W-1:0] k);
    case (pat_e'(s))
      PAT_ONES:  return 8'hFF;
      PAT_1IN8:  return 8'h80;
      PAT_2IN8:  return 8'h42;
      PAT_PULSE: return 8'h08;
      PAT_3IN24: return (k == IDX_W'(0)) ? 8'h44 :
                        (k == IDX_W'(1)) ? 8'h00 : 8'h04;
      PAT_1IN16: return (k == IDX_W'(0)) ? 8'h80 : 8'h00;
      PAT_T14: begin
        if (k < T14_HIGH_END)       return 8'hFF;
        else if (k < T14_ALT1_END)  return 8'hAA;
        else if (k < T14_SPRS1_END) return 8'h10;
        else if (k < T14_ALT2_END)  return 8'hAA;
        else                        return 8'h10;
      end
      PAT_DDS1:  return (k < DDS_HALF) ? 8'hFF : 8'h00;
      PAT_DDS2:  return (k < DDS_HALF) ? 8'h7E : 8'h00;
      PAT_DDS3:  return 8'h4C;
      PAT_DDS4:  return 8'h40;
      PAT_DDS6:  return (k == DDS6_LAST) ? 8'hFF : 8'hFE;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tpg_position.sv
module tpg_position
  import tpg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [IDX_W-1:0] cur_oct_o,
  output logic [BIT_W-1:0] cur_bit_o,
  output logic             first_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OCT_W - 1);

  logic             started_q;
  logic [SEL_W-1:0] last_sel_q;
  logic [IDX_W-1:0] oct_q, oct_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             restart;
  logic [IDX_W-1:0] period;

  assign period  = period_octets(sel_i);
  assign restart = !started_q || (sel_i != last_sel_q);

  always_comb begin
    cur_oct_o = restart ? '0 : oct_q;
    cur_bit_o = restart ? '0 : bit_q;
    first_o   = (cur_oct_o == '0) && (cur_bit_o == '0);
    if (cur_bit_o == LAST_BIT) begin
      bit_d = '0;
      oct_d = (cur_oct_o == period - IDX_W'(1)) ? '0 : cur_oct_o + IDX_W'(1);
    end else begin
      bit_d = cur_bit_o + BIT_W'(1);
      oct_d = cur_oct_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      started_q  <= 1'b0;
      last_sel_q <= '0;
      oct_q      <= '0;
      bit_q      <= '0;
    end else if (en_i) begin
      started_q  <= 1'b1;
      last_sel_q <= sel_i;
      oct_q      <= oct_d;
      bit_q      <= bit_d;
    end
  end

  // Stored position always lies inside the period of the stored pattern
  p_oct_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    started_q |-> (oct_q < period_octets(last_sel_q)));

  // A pattern switch on an enabled bit leaves the position just past bit 0
  p_switch_restart_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && started_q && (sel_i != last_sel_q))
      |=> (oct_q == '0 && bit_q == BIT_W'(1)));
endmodule

// File: rtl/tpg_octet_src.sv
module tpg_octet_src
  import tpg_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0] oct_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             bit_o
);
  logic [OCT_W-1:0] octet;

  assign octet = octet_of(sel_i, oct_i);

  generate
    if (MSB_FIRST) begin : g_msb
      assign bit_o = octet[BIT_W'(OCT_W - 1) - bit_i];
    end else begin : g_lsb
      assign bit_o = octet[bit_i];
    end
  endgenerate
endmodule

// File: rtl/ds1_pattern_gen.sv
module ds1_pattern_gen
  import tpg_pkg::*;
#(
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             bit_en_i,
  input  logic [SEL_W-1:0] pat_sel_i,
  output logic             bit_o,
  output logic             sop_o
);
  logic [IDX_W-1:0] cur_oct;
  logic [BIT_W-1:0] cur_bit;
  logic             first;
  logic             next_bit;
  logic             armed_q;

  tpg_position u_pos (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (bit_en_i),
    .sel_i     (pat_sel_i),
    .cur_oct_o (cur_oct),
    .cur_bit_o (cur_bit),
    .first_o   (first)
  );

  tpg_octet_src #(.MSB_FIRST(MSB_FIRST)) u_src (
    .sel_i (pat_sel_i),
    .oct_i (cur_oct),
    .bit_i (cur_bit),
    .bit_o (next_bit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bit_o <= 1'b0;
      sop_o <= 1'b0;
    end else if (bit_en_i) begin
      bit_o <= next_bit;
      sop_o <= first;
    end else begin
      sop_o <= 1'b0;
    end
  end

  // Qualifies $past-based checks to cycles whose history is after reset
  always_ff @(posedge clk_i) begin
    if (rst_i) armed_q <= 1'b0;
    else       armed_q <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!bit_o && !sop_o));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    !$past(bit_en_i) |-> (!sop_o && $stable(bit_o)));

  p_sop_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    sop_o |=> !sop_o);

  p_all_ones_r7: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    ($past(bit_en_i) && $past(pat_sel_i) == SEL_W'(0)) |-> bit_o);

  p_all_zeros_r7: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    ($past(bit_en_i) && $past(pat_sel_i) == SEL_W'(1)) |-> !bit_o);
endmodule

// File: tb/ds1_pattern_gen_test.sv
module ds1_pattern_gen_test;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [SW-1:0] sel = '0;
  logic bit_o, sop_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ds1_pattern_gen uut (
    .clk_i     (clk),
    .rst_i     (rst),
    .bit_en_i  (en),
    .pat_sel_i (sel),
    .bit_o     (bit_o),
    .sop_o     (sop_o)
  );

  // scoreboard queues
  logic  q_d[$];
  logic  q_s[$];
  string q_t[$];

  // bench-side pattern position model
  int m_pos = 0;
  int m_sel = 0;
  bit m_started = 1'b0;
  logic hold_d = 1'b0;
  logic en_q = 1'b0;
  logic rst_q = 1'b1;
  logic e_d, e_s;
  string e_t;

  function automatic int len_bits(int c);
    case (c)
      4:      return 24;
      5:      return 16;
      7:      return 960;
      8, 9:   return 1600;
      10, 11: return 128;
      12:     return 64;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] exp_octet(int c, int k);
    case (c)
      0: return 8'hFF;
      2: return 8'h80;
      3: return 8'h42;
      4: begin
        if (k == 0) return 8'h44;
        if (k == 2) return 8'h04;
        return 8'h00;
      end
      5: return (k == 0) ? 8'h80 : 8'h00;
      6: return 8'h08;
      7: begin
        if (k >= 100) return 8'h10;
        if (k >= 96)  return 8'hAA;
        if (k >= 76)  return 8'h10;
        if (k >= 72)  return 8'hAA;
        return 8'hFF;
      end
      8:  return (k >= 100) ? 8'h00 : 8'hFF;
      9:  return (k >= 100) ? 8'h00 : 8'h7E;
      10: return 8'h4C;
      11: return 8'h40;
      12: return (k < 7) ? 8'hFE : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_bit(int c, int p);
    logic [7:0] o;
    o = exp_octet(c, p / 8);
    return o[7 - (p % 8)];
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: emit n enabled bits of code, gap idle cycles after each
  task automatic send(int code, int n, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = SW'(code);
      en  = 1'b1;
      if (!m_started || code != m_sel) m_pos = 0;
      q_d.push_back(exp_bit(code, m_pos));
      q_s.push_back(m_pos == 0);
      q_t.push_back(tag);
      m_started = 1'b1;
      m_sel     = code;
      m_pos     = (m_pos + 1) % len_bits(code);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        en = 1'b0;
      end
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic idle_sel(int code, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = SW'(code);
      en  = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_started = 1'b0;
  endtask

  always @(posedge clk) begin
    en_q  <= en;
    rst_q <= rst;
  end

  // monitor: outputs of an enabled edge are compared at the next falling edge
  always @(negedge clk) begin
    if (!done) begin
      if (rst_q) begin
        hold_d = 1'b0;
      end else if (en_q) begin
        if (q_d.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R3 unexpected bit: actual=%0b expected=none", bit_o);
        end else begin
          e_d = q_d.pop_front();
          e_s = q_s.pop_front();
          e_t = q_t.pop_front();
          check(e_t, "bit", bit_o, e_d);
          check(e_t, "start", sop_o, e_s);
        end
        hold_d = bit_o;
      end else begin
        check("R2", "idle start", sop_o, 1'b0);
        check("R2", "idle hold", bit_o, hold_d);
      end
    end
  end

  initial begin
    do_reset();
    check("R1", "reset bit", bit_o, 1'b0);   // R1 outputs cleared
    check("R1", "reset start", sop_o, 1'b0);

    send(2, 16, 1, "R5");     // R5 one in eight, with idle gaps
    send(3, 16, 0, "R5");
    send(6, 8, 2, "R5");
    send(5, 32, 0, "R5");
    send(4, 48, 0, "R6");     // R6 three in 24
    send(0, 16, 0, "R7");     // R7 all ones
    send(1, 16, 1, "R7");
    send(14, 16, 0, "R7");    // R7 unused code
    send(7, 1920, 0, "R8");   // R8 two full periods
    send(8, 3200, 0, "R9");   // R9
    send(9, 1600, 0, "R9");
    send(10, 256, 0, "R10");  // R10
    send(11, 256, 0, "R10");
    send(12, 128, 0, "R10");

    send(7, 40, 0, "R4");     // R4 mid-period switch restarts
    send(4, 30, 0, "R4");
    send(7, 20, 0, "R4");
    idle_sel(3, 3);           // R4 changed and restored while idle
    idle_sel(7, 1);
    send(7, 30, 0, "R4");
    send(12, 70, 0, "R3");    // R3 period wrap marker

    send(8, 50, 0, "R1");     // R1 mid-run reset then restart at bit 0
    do_reset();
    check("R1", "re-reset bit", bit_o, 1'b0);
    check("R1", "re-reset start", sop_o, 1'b0);
    send(8, 20, 0, "R1");

    repeat (4) @(negedge clk);
    total++;
    if (q_d.size() != 0) begin
      bad++;
      $display("FAIL R3 pending items: actual=%0d expected=0", q_d.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule